// File: doc/BRIEF.md
# Two-Operand Arctangent Special-Case Front End

This block sits ahead of a single-precision two-operand arctangent core. Each cycle in which the input strobe is high, it takes a y word and an x word in IEEE binary32 format. It sorts each operand into one of four classes: NaN, infinity, signed zero, or finite nonzero. A subnormal counts as finite nonzero.

A fixed chain of checks then decides the outcome. One outcome is that the block finishes the operation itself, returning either a NaN operand or a constant that is a multiple of pi and takes its sign bit from y. The other outcome is that the operation is ordinary, and the block hands both operands to the core on a dispatch strobe.

A mode input selects how angles are expressed. In radian mode the constants are radian values. In the scaled mode the result is the angle divided by pi, and the same cases return 0.25, 0.5, 0.75 and 1.0 instead. That mode bit travels with each dispatched operation, so the core knows which form to produce.

Every accepted operation shows up exactly one cycle later, either as a result strobe or as a dispatch strobe. The block accepts a new operation every cycle.

Top module: `atan2_front`

## Requirements
- R1: When x is NaN (exponent all ones, fraction nonzero), the result is the x word, bit for bit, whatever y holds.
- R2: When x is not NaN and y is NaN, the result is the y word, bit for bit.
- R3: When x is +inf, the result is pi/4 (0x3F490FDB magnitude) if y is infinite, and zero if y is finite or zero. In both cases bit 31 of the result is the sign bit of y.
- R4: When x is -inf, the result is 3pi/4 (0x4016CBE4) if y is infinite, and pi (0x40490FDB) if y is finite or zero. In both cases the sign bit is taken from y.
- R5: When x is finite or zero and y is infinite, the result is pi/2 (0x3FC90FDB) with the sign of y.
- R6: When x is +0 or -0 and y is finite nonzero, the result is pi/2 with the sign of y.
- R7: When y is zero and x is finite or zero, the result is zero if the sign bit of x is 0, and pi if it is 1. The sign bit of the result is the sign bit of y.
- R8: When both operands are finite nonzero, no result is produced. Instead the dispatch strobe rises and carries y, x and the mode bit unchanged.
- R9: With the scaled mode bit set, the constants pi/4, pi/2, 3pi/4 and pi are replaced by 0x3E800000, 0x3F000000, 0x3F400000 and 0x3F800000. Sign copying is unchanged.
- R10: The result and dispatch strobes are low during reset and in any cycle that follows a cycle without an input strobe. Otherwise exactly one of them is high, in the cycle right after the input strobe.
- R11: A subnormal operand is treated as finite nonzero. A subnormal pair is dispatched, and a subnormal y with a zero x gives pi/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation strobe |
| piScale | input | 1 | 1 selects angle divided by pi, 0 selects radians |
| inY | input | 32 | y operand, binary32 |
| inX | input | 32 | x operand, binary32 |
| resValid | output | 1 | A finished special-case result is on outResult |
| outResult | output | 32 | Special-case result, binary32 |
| dispValid | output | 1 | Operation handed to the arctangent core |
| dispY | output | 32 | Dispatched y |
| dispX | output | 32 | Dispatched x |
| dispPi | output | 1 | Dispatched mode bit |

## Verification
The operand pairs cover each rung of the priority chain, and also pairs that satisfy two rungs at once. Examples are a NaN in both operands, an infinite x with a zero y, and a zero x with an infinite y. Only the correct ordering gives the expected answer for those pairs.

Signed zeros of both signs in each position separate the zero-versus-pi choice, which depends on the sign of x, from the sign copy, which depends on y. Repeating the constant cases in the scaled mode shows that the mode changes the magnitudes but leaves the signs alone. Subnormal operands and back-to-back strobes show that tiny values are not treated as zero and that no operation is lost or doubled.

// File: rtl/atan2_front_pkg.sv
package atan2_front_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIGN_B = WORD_W - 1;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {CLS_FIN, CLS_ZERO, CLS_INF, CLS_NAN} cls_e;

  typedef enum logic [2:0] {
    PICK_X, PICK_Y, PICK_ZERO, PICK_QUARTER, PICK_HALF, PICK_THREEQ, PICK_FULL
  } pick_e;

  typedef struct packed {
    logic  fire;
    logic  toCore;
    pick_e pick;
  } strobe_t;

  localparam word_t RAD_QUARTER = 32'h3F490FDB;
  localparam word_t RAD_HALF    = 32'h3FC90FDB;
  localparam word_t RAD_THREEQ  = 32'h4016CBE4;
  localparam word_t RAD_FULL    = 32'h40490FDB;
  localparam word_t TURN_QUARTER = 32'h3E800000;
  localparam word_t TURN_HALF    = 32'h3F000000;
  localparam word_t TURN_THREEQ  = 32'h3F400000;
  localparam word_t TURN_FULL    = 32'h3F800000;

  function automatic cls_e classify(word_t w);
    logic expOnes;
    logic fracZero;
    logic expZero;
    expOnes  = &w[WORD_W-2:FRAC_W];
    expZero  = ~|w[WORD_W-2:FRAC_W];
    fracZero = ~|w[FRAC_W-1:0];
    if (expOnes && !fracZero)      return CLS_NAN;
    else if (expOnes)              return CLS_INF;
    else if (expZero && fracZero)  return CLS_ZERO;
    else                           return CLS_FIN;
  endfunction
endpackage

// File: rtl/atan2_front_ctrl.sv
module atan2_front_ctrl
  import atan2_front_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    inValid,
  input  word_t   inY,
  input  word_t   inX,
  output strobe_t strobe
);
  word_t operand [2];
  cls_e  opClass [2];

  assign operand[0] = inY;
  assign operand[1] = inX;

  generate
    for (genvar g = 0; g < 2; g++) begin : g_cls
      assign opClass[g] = classify(operand[g]);
    end
  endgenerate

  cls_e yCls, xCls;
  logic xNeg;
  assign yCls = opClass[0];
  assign xCls = opClass[1];
  assign xNeg = inX[SIGN_B];

  always_comb begin
    strobe.fire   = inValid;
    strobe.toCore = 1'b0;
    strobe.pick   = PICK_ZERO;
    if (xCls == CLS_NAN)                         strobe.pick = PICK_X;
    else if (yCls == CLS_NAN)                    strobe.pick = PICK_Y;
    else if (xCls == CLS_INF && !xNeg)           strobe.pick = (yCls == CLS_INF) ? PICK_QUARTER : PICK_ZERO;
    else if (xCls == CLS_INF)                    strobe.pick = (yCls == CLS_INF) ? PICK_THREEQ : PICK_FULL;
    else if (yCls == CLS_INF)                    strobe.pick = PICK_HALF;
    else if (xCls == CLS_ZERO && yCls != CLS_ZERO) strobe.pick = PICK_HALF;
    else if (yCls == CLS_ZERO)                   strobe.pick = xNeg ? PICK_FULL : PICK_ZERO;
    else                                         strobe.toCore = 1'b1;
  end

  // R7: a zero y with an ordinary x picks zero or pi by the sign of x
  assert_zero_y_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && yCls == CLS_ZERO && (xCls == CLS_FIN || xCls == CLS_ZERO))
      |-> (strobe.pick == (xNeg ? PICK_FULL : PICK_ZERO)) && !strobe.toCore);

  // R8: only a pair of finite nonzero operands goes to the core
  assert_core_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.toCore |-> (xCls == CLS_FIN && yCls == CLS_FIN));
endmodule

// File: rtl/atan2_front_dp.sv
module atan2_front_dp
  import atan2_front_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  strobe_t strobe,
  input  logic    piScale,
  input  word_t   inY,
  input  word_t   inX,
  output logic    resValid,
  output word_t   outResult,
  output logic    dispValid,
  output word_t   dispY,
  output word_t   dispX,
  output logic    dispPi
);
  word_t mag;
  word_t resolved;

  always_comb begin
    unique case (strobe.pick)
      PICK_QUARTER: mag = piScale ? TURN_QUARTER : RAD_QUARTER;
      PICK_HALF:    mag = piScale ? TURN_HALF    : RAD_HALF;
      PICK_THREEQ:  mag = piScale ? TURN_THREEQ  : RAD_THREEQ;
      PICK_FULL:    mag = piScale ? TURN_FULL    : RAD_FULL;
      default:      mag = '0;
    endcase
    if (strobe.pick == PICK_X)      resolved = inX;
    else if (strobe.pick == PICK_Y) resolved = inY;
    else                            resolved = {inY[SIGN_B], mag[SIGN_B-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resValid  <= 1'b0;
      dispValid <= 1'b0;
      outResult <= '0;
      dispY     <= '0;
      dispX     <= '0;
      dispPi    <= 1'b0;
    end else begin
      resValid  <= strobe.fire && !strobe.toCore;
      dispValid <= strobe.fire && strobe.toCore;
      if (strobe.fire && !strobe.toCore) outResult <= resolved;
      if (strobe.fire && strobe.toCore) begin
        dispY  <= inY;
        dispX  <= inX;
        dispPi <= piScale;
      end
    end
  end

  assert_one_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({resValid, dispValid}));

  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fire |=> (resValid || dispValid));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.fire |=> !(resValid || dispValid));

  assert_nan_x_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && classify(inX) == CLS_NAN) |=> (resValid && outResult == $past(inX)));

  assert_nan_y_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && classify(inX) != CLS_NAN && classify(inY) == CLS_NAN)
      |=> (resValid && outResult == $past(inY)));

  // R3 R4 R5 R6: every non-NaN constant carries the sign of y
  assert_sign_y_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && classify(inX) != CLS_NAN && classify(inY) != CLS_NAN)
      |=> (dispValid || outResult[SIGN_B] == $past(inY[SIGN_B])));

  assert_disp_ops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && strobe.toCore)
      |=> (dispY == $past(inY) && dispX == $past(inX) && dispPi == $past(piScale)));

  assert_scaled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.fire && piScale && strobe.pick == PICK_FULL)
      |=> (outResult[SIGN_B-1:0] == TURN_FULL[SIGN_B-1:0]));
endmodule

// File: rtl/atan2_front.sv
module atan2_front
  import atan2_front_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        piScale,
  input  logic [31:0] inY,
  input  logic [31:0] inX,
  output logic        resValid,
  output logic [31:0] outResult,
  output logic        dispValid,
  output logic [31:0] dispY,
  output logic [31:0] dispX,
  output logic        dispPi
);
  strobe_t strobe;

  atan2_front_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .inY(inY), .inX(inX), .strobe(strobe)
  );

  atan2_front_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .piScale(piScale),
    .inY(inY), .inX(inX),
    .resValid(resValid), .outResult(outResult),
    .dispValid(dispValid), .dispY(dispY), .dispX(dispX), .dispPi(dispPi)
  );
endmodule

// File: tb/atan2_front_bench.sv
module atan2_front_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        piScale = 1'b0;
  logic [31:0] inY = '0;
  logic [31:0] inX = '0;
  logic        resValid, dispValid, dispPi;
  logic [31:0] outResult, dispY, dispX;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  atan2_front u_atan2_front (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .piScale(piScale),
    .inY(inY), .inX(inX), .resValid(resValid), .outResult(outResult),
    .dispValid(dispValid), .dispY(dispY), .dispX(dispX), .dispPi(dispPi)
  );

  localparam int NV = 26;
  // {req tag(4), piScale, y, x, expect dispatch, expected result}
  localparam logic [101:0] VEC [NV] = '{
    {4'd1,  1'b0, 32'hFFC00123, 32'h7FA00001, 1'b0, 32'h7FA00001}, // R1 both NaN, x wins
    {4'd2,  1'b0, 32'hFFC00123, 32'h3F800000, 1'b0, 32'hFFC00123}, // R2
    {4'd3,  1'b0, 32'h7F800000, 32'h7F800000, 1'b0, 32'h3F490FDB}, // R3
    {4'd3,  1'b0, 32'hFF800000, 32'h7F800000, 1'b0, 32'hBF490FDB}, // R3
    {4'd3,  1'b0, 32'hC0000000, 32'h7F800000, 1'b0, 32'h80000000}, // R3
    {4'd3,  1'b0, 32'h00000000, 32'h7F800000, 1'b0, 32'h00000000}, // R3
    {4'd4,  1'b0, 32'hFF800000, 32'hFF800000, 1'b0, 32'hC016CBE4}, // R4
    {4'd4,  1'b0, 32'h3F800000, 32'hFF800000, 1'b0, 32'h40490FDB}, // R4
    {4'd4,  1'b0, 32'h80000000, 32'hFF800000, 1'b0, 32'hC0490FDB}, // R4
    {4'd5,  1'b0, 32'h7F800000, 32'hC0000000, 1'b0, 32'h3FC90FDB}, // R5
    {4'd5,  1'b0, 32'hFF800000, 32'h00000000, 1'b0, 32'hBFC90FDB}, // R5
    {4'd6,  1'b0, 32'h3F800000, 32'h80000000, 1'b0, 32'h3FC90FDB}, // R6
    {4'd6,  1'b0, 32'hC0000000, 32'h00000000, 1'b0, 32'hBFC90FDB}, // R6
    {4'd7,  1'b0, 32'h00000000, 32'h00000000, 1'b0, 32'h00000000}, // R7
    {4'd7,  1'b0, 32'h80000000, 32'h80000000, 1'b0, 32'hC0490FDB}, // R7
    {4'd7,  1'b0, 32'h80000000, 32'h3F800000, 1'b0, 32'h80000000}, // R7
    {4'd7,  1'b0, 32'h00000000, 32'hC0000000, 1'b0, 32'h40490FDB}, // R7
    {4'd8,  1'b0, 32'hC0000000, 32'h3F800000, 1'b1, 32'h00000000}, // R8
    {4'd11, 1'b0, 32'h3F800000, 32'h00000001, 1'b1, 32'h00000000}, // R11
    {4'd11, 1'b0, 32'h80000001, 32'h00000000, 1'b0, 32'hBFC90FDB}, // R11
    {4'd9,  1'b1, 32'hFF800000, 32'h7F800000, 1'b0, 32'hBE800000}, // R9
    {4'd9,  1'b1, 32'h7F800000, 32'hFF800000, 1'b0, 32'h3F400000}, // R9
    {4'd9,  1'b1, 32'h80000000, 32'hC0000000, 1'b0, 32'hBF800000}, // R9
    {4'd9,  1'b1, 32'h3F800000, 32'h00000000, 1'b0, 32'h3F000000}, // R9
    {4'd1,  1'b1, 32'h3F800000, 32'h7FC00000, 1'b0, 32'h7FC00000}, // R1 in scaled mode
    {4'd8,  1'b1, 32'h40000000, 32'hBF800000, 1'b1, 32'h00000000}  // R8 mode bit forwarded
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    // R10: outputs stay low while reset is held, even with strobe high
    inValid = 1'b1; inX = 32'h7FC00000; inY = 32'h3F800000;
    repeat (3) @(negedge clk);
    check("R10 reset resValid", {31'b0, resValid}, 32'd0);
    check("R10 reset dispValid", {31'b0, dispValid}, 32'd0);
    rst_n = 1'b1; inValid = 1'b0;
    @(negedge clk);
    check("R10 idle resValid", {31'b0, resValid}, 32'd0);
    check("R10 idle dispValid", {31'b0, dispValid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i][101:98], i);
      piScale = VEC[i][97];
      inY = VEC[i][96:65];
      inX = VEC[i][64:33];
      inValid = 1'b1;
      @(negedge clk);
      if (VEC[i][32]) begin
        check({tag, " dispValid"}, {31'b0, dispValid}, 32'd1);
        check({tag, " resValid"}, {31'b0, resValid}, 32'd0);
        check({tag, " dispY"}, dispY, VEC[i][96:65]);
        check({tag, " dispX"}, dispX, VEC[i][64:33]);
        check({tag, " dispPi"}, {31'b0, dispPi}, {31'b0, VEC[i][97]});
      end else begin
        check({tag, " resValid"}, {31'b0, resValid}, 32'd1);
        check({tag, " dispValid"}, {31'b0, dispValid}, 32'd0);
        check({tag, " result"}, outResult, VEC[i][31:0]);
      end
    end

    // R10: dropping the strobe clears both outputs one cycle later
    inValid = 1'b0; inX = 32'h3F800000; inY = 32'h3F800000;
    @(negedge clk);
    check("R10 after-stream resValid", {31'b0, resValid}, 32'd0);
    check("R10 after-stream dispValid", {31'b0, dispValid}, 32'd0);
    // R10: a single strobe after a gap
    inValid = 1'b1; piScale = 1'b0; inX = 32'hFF800000; inY = 32'h00000000;
    @(negedge clk);
    inValid = 1'b0;
    check("R4 gap result", outResult, 32'h40490FDB);
    check("R10 gap resValid", {31'b0, resValid}, 32'd1);
    @(negedge clk);
    check("R10 gap trailing resValid", {31'b0, resValid}, 32'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R10 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule